// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit sits between a 16-bit processor core and a data RAM built from two byte-wide lanes. The lanes share one word index and have separate write strobes. The core presents a 16-bit byte address, a read or write request, a byte-or-word size flag and write data. The unit steers the request onto the lanes and returns aligned read data one cycle later. It flags misaligned word accesses with a one-cycle trap pulse. It also produces the post-incremented pointer that a register-indirect access would write back.

Only a window of `RAM_WORDS` words starting at `RAM_BASE` is backed by storage. The default is 1K words at 0x0800, so the window spans 0x0800 to 0x0FFF. Every other address reads as zero. This includes the low register region 0x0000 to 0x07FF and the upper half of the map, where bit 15 is set. Writes to those addresses are dropped without a trap.

Top module: `dmau_top`

## Requirements
- R1: After a synchronous reset, `rsp_valid`, `addr_trap` and `rsp_rdata` are all zero.
- R2: A word read at an even address inside the window causes `rsp_valid` to rise in the next cycle. In that cycle `rsp_rdata` carries the stored word: the odd-address byte is on [15:8] and the even-address byte is on [7:0]. `rsp_valid` is low in any cycle that does not follow a read request.
- R3: A byte read returns the addressed byte on `rsp_rdata[7:0]`. Address bit 0 = 0 selects the even (low) lane and address bit 0 = 1 selects the odd (high) lane. `rsp_rdata[15:8]` is zero.
- R4: A byte write stores `req_wdata[7:0]` into the single lane chosen by address bit 0. The other byte of that word keeps its value.
- R5: A word write at an even address stores `req_wdata[7:0]` at the even byte and `req_wdata[15:8]` at the odd byte.
- R6: A word read with address bit 0 set still completes: it returns the word at the address with bit 0 cleared. `addr_trap` is high in the same response cycle.
- R7: A word write with address bit 0 set changes no memory byte, and `addr_trap` is high in the cycle after the request.
- R8: Any read outside [RAM_BASE, RAM_BASE + 2*RAM_WORDS), including any address with bit 15 set, returns all zero bits. An aligned access of this kind raises no trap.
- R9: A write outside the window changes no memory byte and raises no trap.
- R10: `ptr_post` equals `req_addr + 1` when `req_byte` is 1 and `req_addr + 2` when `req_byte` is 0, modulo 2^16.
- R11: `addr_trap` is high exactly in the cycle after a word request (`req_byte` = 0) with address bit 0 set. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address, also the base pointer |
| req_wdata | input | 16 | Write data; byte writes use [7:0] |
| ptr_post | output | 16 | Post-incremented pointer (combinational) |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 16 | Aligned read data |
| addr_trap | output | 1 | Misaligned word access pulse |

## Verification
The access path is driven with even and odd word reads and writes, and with byte reads and writes on both lanes. Byte writes followed by word reads show whether the untouched lane survives. Odd-address word reads and writes are contrasted to tell "completes then traps" apart from "suppressed then traps". Reads and writes just below, just above and far outside the window show that out-of-range reads are zero-filled and that out-of-range writes do not alias into the RAM. A long mixed pseudo-random sequence, compared each cycle against a byte-array model, covers interleavings that the directed cases miss. Pointer results are checked at the top of the address space, where wraparound occurs.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

    // request as seen by the decoder
    typedef struct packed {
        logic      rd;
        logic      wr;
        acc_size_e size;
        logic [15:0] addr;
        logic [15:0] wdata;
    } acc_req_t;

    // per-request state carried to the response stage
    typedef struct packed {
        logic rd;
        logic in_range;
        logic byte_acc;
        logic hi_lane;
        logic trap;
    } rsp_ctl_t;

    function automatic logic [15:0] ptr_step(acc_size_e size);
        return (size == SZ_BYTE) ? 16'd1 : 16'd2;
    endfunction

endpackage

// File: rtl/dmau_decode.sv
module dmau_decode
    import dmau_pkg::*;
#(
    parameter int RAM_WORDS = 1024,
    parameter int RAM_BASE  = 16'h0800,
    localparam int IDX_W    = $clog2(RAM_WORDS)
) (
    input  acc_req_t         req,
    output logic             in_range,
    output logic             misalign,
    output logic [IDX_W-1:0] word_idx,
    output logic [1:0]       lane_we,
    output logic [15:0]      lane_wd,
    output logic [15:0]      ptr_post
);
    localparam logic [16:0] BASE17 = 17'(RAM_BASE);
    localparam logic [16:0] SPAN17 = 17'(2 * RAM_WORDS);

    logic [16:0] offset;
    logic        wr_ok;

    always_comb begin
        offset   = {1'b0, req.addr} - BASE17;
        in_range = !req.addr[15] && !offset[16] && (offset < SPAN17);
        word_idx = offset[IDX_W:1];
        misalign = (req.size == SZ_WORD) && req.addr[0];
        wr_ok    = req.wr && in_range && !misalign;
        lane_we[0] = wr_ok && ((req.size == SZ_WORD) || !req.addr[0]);
        lane_we[1] = wr_ok && ((req.size == SZ_WORD) ||  req.addr[0]);
        lane_wd[7:0]  = req.wdata[7:0];
        lane_wd[15:8] = (req.size == SZ_BYTE) ? req.wdata[7:0] : req.wdata[15:8];
        ptr_post = req.addr + ptr_step(req.size);
    end

    // R7: a misaligned word access never strobes a lane
    always_comb begin
        assert_no_strobe_on_misalign_R7: assert (!(misalign && (lane_we != 2'b00)));
    end
endmodule

// File: rtl/dmau_lane_ram.sv
module dmau_lane_ram #(
    parameter int RAM_WORDS = 1024,
    localparam int IDX_W    = $clog2(RAM_WORDS),
    localparam int LANES    = 2
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic             re,
    input  logic [LANES-1:0] we,
    input  logic [15:0]      wd,
    output logic [15:0]      rd
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] store [RAM_WORDS];
        always_ff @(posedge clk) begin
            if (we[l]) store[idx] <= wd[8*l +: 8];
            if (re)    rd[8*l +: 8] <= store[idx];
        end
    end
endmodule

// File: rtl/dmau_read_align.sv
module dmau_read_align
    import dmau_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rsp_ctl_t    ctl_in,
    input  logic [15:0] lane_rd,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        addr_trap
);
    rsp_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_in;
    end

    always_comb begin
        rsp_valid = ctl_q.rd;
        addr_trap = ctl_q.trap;
        if (!ctl_q.rd || !ctl_q.in_range)
            rsp_rdata = 16'h0000;
        else if (ctl_q.byte_acc)
            rsp_rdata = {8'h00, ctl_q.hi_lane ? lane_rd[15:8] : lane_rd[7:0]};
        else
            rsp_rdata = lane_rd;
    end

    // R3: byte responses never carry data in the upper byte
    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_in.rd && ctl_in.byte_acc) |=> (rsp_rdata[15:8] == 8'h00));
endmodule

// File: rtl/dmau_top.sv
module dmau_top
    import dmau_pkg::*;
#(
    parameter int RAM_WORDS = 1024,
    parameter int RAM_BASE  = 16'h0800,
    localparam int IDX_W    = $clog2(RAM_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_byte,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic [15:0] ptr_post,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        addr_trap
);
    acc_req_t         req;
    rsp_ctl_t         ctl;
    logic             dec_in_range;
    logic             dec_misalign;
    logic [IDX_W-1:0] dec_idx;
    logic [1:0]       dec_we;
    logic [15:0]      dec_wd;
    logic [15:0]      ram_rd;

    always_comb begin
        req.rd    = req_valid && !req_write;
        req.wr    = req_valid &&  req_write;
        req.size  = req_byte ? SZ_BYTE : SZ_WORD;
        req.addr  = req_addr;
        req.wdata = req_wdata;
    end

    dmau_decode #(.RAM_WORDS(RAM_WORDS), .RAM_BASE(RAM_BASE)) u_decode (
        .req      (req),
        .in_range (dec_in_range),
        .misalign (dec_misalign),
        .word_idx (dec_idx),
        .lane_we  (dec_we),
        .lane_wd  (dec_wd),
        .ptr_post (ptr_post)
    );

    dmau_lane_ram #(.RAM_WORDS(RAM_WORDS)) u_ram (
        .clk (clk),
        .idx (dec_idx),
        .re  (req.rd && dec_in_range),
        .we  (dec_we),
        .wd  (dec_wd),
        .rd  (ram_rd)
    );

    always_comb begin
        ctl.rd       = req.rd;
        ctl.in_range = dec_in_range;
        ctl.byte_acc = req_byte;
        ctl.hi_lane  = req_addr[0];
        ctl.trap     = req_valid && dec_misalign;
    end

    dmau_read_align u_align (
        .clk       (clk),
        .rst       (rst),
        .ctl_in    (ctl),
        .lane_rd   (ram_rd),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .addr_trap (addr_trap)
    );

    assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    assert_no_rsp_without_read_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
    assert_trap_only_misaligned_R11: assert property (@(posedge clk) disable iff (rst)
        addr_trap |-> $past(req_valid && !req_byte && req_addr[0]));
    assert_trap_follows_misaligned_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_byte && req_addr[0]) |=> addr_trap);
    assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !dec_in_range) |=> (rsp_rdata == 16'h0000));
    assert_byte_write_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_byte) |-> $onehot0(dec_we));
endmodule

// File: tb/dmau_top_test.sv
`timescale 1ns/1ps
module dmau_top_test;
    localparam int WORDS = 1024;
    localparam int BASE  = 16'h0800;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_byte;
    logic [15:0] req_addr, req_wdata;
    logic [15:0] ptr_post, rsp_rdata;
    logic        rsp_valid, addr_trap;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] model [2*WORDS];

    always #2.5 clk = ~clk;

    dmau_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .ptr_post(ptr_post), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .addr_trap(addr_trap)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit inside_win(logic [15:0] a);
        return !a[15] && (int'(a) >= BASE) && (int'(a) < BASE + 2*WORDS);
    endfunction

    // one access, then one response cycle checked at the falling edge
    task automatic access(bit wr, bit byt, logic [15:0] a, logic [15:0] wd, string tag);
        logic [15:0] exp_rd;
        logic [15:0] exp_ptr;
        bit          mis;
        int          off;
        mis = !byt && a[0];
        off = int'(a) - BASE;
        exp_rd = 16'h0000;
        if (!wr && inside_win(a)) begin
            if (byt) exp_rd = {8'h00, model[off]};
            else     exp_rd = {model[off | 1], model[off & ~1]};
        end
        if (wr && inside_win(a) && !mis) begin
            if (byt) model[off] = wd[7:0];
            else begin
                model[off]     = wd[7:0];
                model[off + 1] = wd[15:8];
            end
        end
        req_valid = 1'b1; req_write = wr; req_byte = byt;
        req_addr = a; req_wdata = wd;
        #1;
        exp_ptr = a + (byt ? 16'd1 : 16'd2);
        check("R10", ptr_post, exp_ptr, "ptr_post");
        @(posedge clk);
        #0.5;
        req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
        req_addr = 16'h0; req_wdata = 16'h0;
        @(negedge clk);
        check("R2", {15'h0, rsp_valid}, {15'h0, !wr}, "rsp_valid");
        check(mis ? (wr ? "R7" : "R6") : "R11", {15'h0, addr_trap}, {15'h0, mis}, "addr_trap");
        if (!wr) check(tag, rsp_rdata, exp_rd, "rsp_rdata");
        @(negedge clk);
        check("R11", {15'h0, addr_trap}, 16'h0, "trap idle");
        check("R2", {15'h0, rsp_valid}, 16'h0, "valid idle");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lfsr;
        rst = 1'b1; req_valid = 0; req_write = 0; req_byte = 0;
        req_addr = 0; req_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {14'h0, rsp_valid, addr_trap}, 16'h0, "reset flags");
        check("R1", rsp_rdata, 16'h0, "reset data");
        rst = 1'b0;
        @(negedge clk);

        // prefill whole window through word writes (R5)
        for (int i = 0; i < WORDS; i++)
            access(1, 0, 16'(BASE + 2*i), 16'(i * 16'h0101 ^ 16'h3C5A), "R5");

        access(1, 0, 16'h0800, 16'h1234, "R5");
        access(1, 0, 16'h0802, 16'hABCD, "R5");
        access(1, 0, 16'h0FFE, 16'h5A5A, "R5");
        access(0, 0, 16'h0800, 16'h0, "R2");
        access(0, 0, 16'h0802, 16'h0, "R5");
        access(0, 0, 16'h0FFE, 16'h0, "R2");

        access(0, 1, 16'h0800, 16'h0, "R3");
        access(0, 1, 16'h0801, 16'h0, "R3");
        access(0, 1, 16'h0FFF, 16'h0, "R3");

        access(1, 1, 16'h0803, 16'h0077, "R4");
        access(0, 0, 16'h0802, 16'h0, "R4");
        access(1, 1, 16'h0802, 16'hFF11, "R4");
        access(0, 0, 16'h0802, 16'h0, "R4");

        access(0, 0, 16'h0803, 16'h0, "R6");
        access(1, 0, 16'h0801, 16'hDEAD, "R7");
        access(0, 0, 16'h0800, 16'h0, "R7");

        access(0, 0, 16'h0000, 16'h0, "R8");
        access(0, 0, 16'h07FE, 16'h0, "R8");
        access(0, 1, 16'h07FF, 16'h0, "R8");
        access(0, 0, 16'h1000, 16'h0, "R8");
        access(0, 0, 16'h8800, 16'h0, "R8");
        access(0, 0, 16'hFFFE, 16'h0, "R8");

        access(1, 0, 16'h1000, 16'hBEEF, "R9");
        access(1, 0, 16'h8800, 16'hBEEF, "R9");
        access(1, 1, 16'h07FF, 16'h00EE, "R9");
        access(0, 0, 16'h0800, 16'h0, "R9");
        access(0, 0, 16'h0FFE, 16'h0, "R9");

        access(0, 1, 16'hFFFF, 16'h0, "R10");
        access(0, 0, 16'hFFFE, 16'h0, "R10");

        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = 16'(BASE - 16 + int'(lfsr[11:0] % 12'd2080));
            access(lfsr[12], lfsr[13], a, lfsr[31:16], "R2");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule